// File: doc/BRIEF.md
# GPIO Input Glitch Qualifier

This block sits between asynchronous general-purpose input pins and the logic that uses them. Every pin first crosses into the system clock domain through a two-stage synchronizer. A shared divider then produces a sample strobe once every 2×n clock cycles, where n is an 8-bit period value. On each strobe, every pin pushes its synchronized level into a private six-deep sample history. The qualified output for a pin moves to a new level only when all six stored samples agree on that level. A short pulse or glitch therefore never reaches the output.

A period value of zero switches the block into bypass. The synchronized level is copied to the output register on every clock, and the history is left untouched. Writing a different period value restarts the shared divider, so the first strobe under the new value comes a full 2×n cycles later. The sample histories are kept across such a change.

Top module: `gpin_qualifier`

## Requirements
- R1: Reset (active-low `rst_n`) clears every qualified output bit, every sample history bit and the interval counter to 0.
- R2: With `qual_period` = 0, each output bit follows its raw input with a fixed latency of three clock edges: two synchronizer stages, then the output register.
- R3: With `qual_period` = 0, a raw pulse held for 2 clock cycles appears on the output for 2 clock cycles.
- R4: For a nonzero period n, one strobe shared by all pins occurs every 2×n clock cycles, so two strobes are never on adjacent cycles.
- R5: With a nonzero period, an output bit changes only on a strobe cycle, and only to a level that the newest six strobed samples of that pin all show.
- R6: A synchronized level held for 10×n cycles or fewer never changes the output, whatever its phase against the strobe.
- R7: A synchronized level held for 12×n cycles or more is always taken up by the output, whatever its phase against the strobe.
- R8: When `qual_period` takes a value different from the previous cycle, the interval counter restarts. The next strobe falls 2×n cycles after the first edge that sees the new value, and the sample histories are kept.
- R9: Pins are filtered independently: each keeps its own history, and a glitch on one pin has no effect on the output of another.
- R10: The full range up to n = 255 works: an interval of 510 cycles with no counter overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_raw | input | NUM_PINS | Asynchronous raw pin levels |
| qual_period | input | PERIOD_W | Sampling period n; 0 selects bypass |
| pin_qual | output | NUM_PINS | Qualified pin levels |

## Verification
The bench builds the block with NUM_PINS = 4 and the default 8-bit period. Four pins are enough to drive a long level, a glitch and a quiet line side by side, and the full period range puts the 510-cycle interval at n = 255 within reach. Levels of exactly 10×n and 12×n cycles are driven at every phase offset against the strobe for n = 1 and n = 3. The divider restart is timed to the exact edge by changing the period together with an input level.

// File: rtl/gpq_pkg.sv
`timescale 1ns/1ps
package gpq_pkg;

  // Decision taken by a pin filter for its output register this cycle.
  typedef enum logic [1:0] {
    QA_HOLD   = 2'd0,
    QA_SET_LO = 2'd1,
    QA_SET_HI = 2'd2,
    QA_FOLLOW = 2'd3
  } qual_act_e;

endpackage

// File: rtl/gpq_sync.sv
`timescale 1ns/1ps
module gpq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpq_divider.sv
`timescale 1ns/1ps
module gpq_divider #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  output logic                strobe,
  output logic                bypass
);

  localparam int CW = PERIOD_W + 1;

  logic [PERIOD_W-1:0] per_q;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [CW-1:0]       lim;
  logic                changed, at_lim;

  // Next-state logic
  always_comb begin
    changed = (period != per_q);
    bypass  = (period == '0);
    lim     = {period, 1'b0} - CW'(1);
    at_lim  = (cnt_q == lim);
    strobe  = !changed && !bypass && at_lim;
    if (changed || bypass || at_lim) cnt_d = '0;
    else                             cnt_d = cnt_q + CW'(1);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
    end else begin
      per_q <= period;
      cnt_q <= cnt_d;
    end
  end

  // Strobes never fall on adjacent cycles (interval is at least 2)
  assert_strobe_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // A period change restarts the count: no strobe on the following cycle
  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (period != $past(period)) |-> !strobe);

  // Bypass never produces a strobe
  assert_no_strobe_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !strobe);

endmodule

// File: rtl/gpq_pin_filter.sv
`timescale 1ns/1ps
module gpq_pin_filter
  import gpq_pkg::*;
#(
  parameter int HIST_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp,
  input  logic strobe,
  input  logic bypass,
  output logic q
);

  logic [HIST_LEN-1:0] hist_q, hist_d;
  logic                q_q, q_d;
  logic                hist_en;
  qual_act_e           act;

  // Next-state logic
  always_comb begin
    hist_en = strobe && !bypass;
    hist_d  = hist_en ? {hist_q[HIST_LEN-2:0], samp} : hist_q;
    if (bypass)                 act = QA_FOLLOW;
    else if (hist_en && &hist_d)  act = QA_SET_HI;
    else if (hist_en && ~|hist_d) act = QA_SET_LO;
    else                        act = QA_HOLD;
    case (act)
      QA_FOLLOW: q_d = samp;
      QA_SET_HI: q_d = 1'b1;
      QA_SET_LO: q_d = 1'b0;
      default:   q_d = q_q;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      q_q    <= 1'b0;
    end else begin
      if (hist_en) hist_q <= hist_d;
      q_q <= q_d;
    end
  end

  assign q = q_q;

  // Filtered output moves only on a strobe cycle
  assert_move_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !strobe) |=> $stable(q));

  // A new level needs the newest sample to match it
  assert_new_level_sampled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && strobe && (samp == q)) |=> $stable(q));

endmodule

// File: rtl/gpin_qualifier.sv
`timescale 1ns/1ps
module gpin_qualifier #(
  parameter int NUM_PINS    = 8,
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [PERIOD_W-1:0] qual_period,
  output logic [NUM_PINS-1:0] pin_qual
);

  localparam int LAT = SYNC_STAGES + 1;

  logic [NUM_PINS-1:0] pin_sync;
  logic                strobe, bypass;

  gpq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_raw),
    .dout  (pin_sync)
  );

  gpq_divider #(.PERIOD_W(PERIOD_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .period (qual_period),
    .strobe (strobe),
    .bypass (bypass)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpq_pin_filter #(.HIST_LEN(HIST_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .samp   (pin_sync[p]),
      .strobe (strobe),
      .bypass (bypass),
      .q      (pin_qual[p])
    );
  end

  // Edges since reset release, saturating, for the latency check below
  logic [3:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 age_q <= '0;
    else if (age_q != 4'(LAT + 1)) age_q <= age_q + 4'd1;
  end

  // Bypass: output equals the raw input LAT edges earlier
  assert_bypass_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 4'(LAT + 1) && $past(qual_period) == '0) |-> pin_qual == $past(pin_raw, LAT));

endmodule

// File: tb/gpin_qualifier_bench.sv
`timescale 1ns/1ps
module gpin_qualifier_bench;

  localparam int NP = 4;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_raw;
  logic [PW-1:0] qual_period;
  logic [NP-1:0] pin_qual;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpin_qualifier #(.NUM_PINS(NP), .PERIOD_W(PW)) u_gpin_qualifier (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_raw     (pin_raw),
    .qual_period (qual_period),
    .pin_qual    (pin_qual)
  );

  task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Advance k rising edges, then settle 1 ns past the last one
  task automatic tick(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  // Set a period and let every history fill with zeros
  task automatic settle(int n);
    pin_raw     = '0;
    qual_period = PW'(n);
    tick(24 * (n == 0 ? 1 : n) + 8);
  endtask

  task automatic t_reset();
    pin_raw = '0; qual_period = '0;
    do_reset();
    check("R1 reset state", pin_qual, '0);
  endtask

  task automatic t_bypass();
    settle(0);
    pin_raw = 4'b0001;             // before edge e0
    tick(2);
    check("R2 bypass latency before e2", pin_qual, 4'b0000);
    pin_raw = 4'b0000;             // 2-cycle pulse ends
    tick(1);
    check("R2 bypass latency after e2", pin_qual, 4'b0001);
    tick(1);
    check("R3 bypass pulse second cycle", pin_qual, 4'b0001);
    tick(1);
    check("R3 bypass pulse ends", pin_qual, 4'b0000);
  endtask

  // Drive pin 1 high for width cycles at a phase offset, watch for any rise
  task automatic t_level(string req, int n, int width, int phase, bit expect_seen);
    bit seen = 0;
    settle(n);
    tick(phase);
    pin_raw = 4'b0010;
    for (int i = 0; i < width; i++) begin
      tick(1);
      if (pin_qual[1]) seen = 1;
    end
    pin_raw = 4'b0000;
    for (int i = 0; i < 16 * n + 8; i++) begin
      tick(1);
      if (pin_qual[1]) seen = 1;
    end
    check(req, {3'b000, seen}, {3'b000, expect_seen});
    if (expect_seen) begin
      tick(14 * n);
      check({req, " recovers low"}, pin_qual, '0);
    end
  endtask

  task automatic t_short_levels();
    for (int ph = 0; ph < 2; ph++) t_level("R6 10n level n=1 ignored", 1, 10, ph, 1'b0);
    for (int ph = 0; ph < 6; ph++) t_level("R6 10n level n=3 ignored", 3, 30, ph, 1'b0);
  endtask

  task automatic t_long_levels();
    for (int ph = 0; ph < 2; ph++) t_level("R7 12n level n=1 taken", 1, 12, ph, 1'b1);
    for (int ph = 0; ph < 6; ph++) t_level("R7 12n level n=3 taken", 3, 36, ph, 1'b1);
  endtask

  task automatic t_independent();
    settle(2);
    pin_raw = 4'b1011;             // pin1 is only a glitch
    tick(15);
    pin_raw = 4'b1001;
    tick(45);
    check("R9 pins independent", pin_qual, 4'b1001);
    pin_raw = 4'b0000;
    tick(60);
    check("R9 pins return low", pin_qual, 4'b0000);
  endtask

  task automatic t_restart();
    settle(1);
    qual_period = 8'd20;           // change and level both before edge e0
    pin_raw     = 4'b0100;
    tick(240);
    check("R8 no update before sixth strobe", pin_qual, 4'b0000);
    tick(1);
    check("R8 update at edge 240 after restart", pin_qual, 4'b0100);
  endtask

  task automatic t_history_kept();
    // History of pin 2 is all ones; change period, glitch low briefly
    qual_period = 8'd4;
    pin_raw     = 4'b0000;
    tick(20);                      // shorter than 10n = 40
    pin_raw     = 4'b0100;
    tick(100);
    check("R8 history kept across period change", pin_qual, 4'b0100);
  endtask

  task automatic t_max_period();
    settle(0);
    qual_period = 8'd255;
    tick(4);
    pin_raw = 4'b1000;
    tick(5 * 510);
    check("R10 n=255 not yet taken", pin_qual, 4'b0000);
    tick(2 * 510);
    check("R10 n=255 taken", pin_qual, 4'b1000);
    rst_n = 1'b0;
    tick(2);
    check("R1 reset clears output", pin_qual, 4'b0000);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_short_levels();
    t_long_levels();
    t_independent();
    t_restart();
    t_history_kept();
    t_max_period();
    finish_run();
  end

  initial begin
    #(5 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule